// File: doc/BRIEF.md
# Bi-Endian Load/Store Data Aligner

This block sits between a 32-bit register datapath and a 32-bit memory bus. For each request it takes an access size and the low address bits. On the write side it spreads register data across the bus byte lanes and raises a strobe for each lane the access touches. On the read side it picks the addressed lanes out of the returned bus word and sign-extends a byte or a word result to the full datapath width. The byte-lane mapping follows a big-endian or little-endian mode. That mode is captured from a configuration pin while reset is asserted and does not change afterwards.

A second path extends an 8-bit literal to 32 bits. It sign-extends for arithmetic-class operations (move, add, compare-for-equality). It zero-extends for logic-class operations (test, AND, OR, XOR). All results are registered and appear one clock after the request, together with a response-valid flag. A request whose address does not suit its size raises an error flag, and that request gets no strobes.

Top module: `endian_aligner`

## Requirements
- R1: The endian mode is taken from `cfg_big_endian` while `rst_n` is low (1 = big-endian) and holds until the next reset; changing the pin later has no effect on lane mapping.
- R2: Little-endian strobes: `byte_en[k]` covers bits 8k+7:8k. A byte at address a sets bit a. A word at address 0 sets 4'b0011 and at address 2 sets 4'b1100. A longword sets 4'b1111.
- R3: Big-endian strobes: a byte at address a sets bit 3-a. A word at address 0 sets 4'b1100 and at address 2 sets 4'b0011. A longword sets 4'b1111.
- R4: `req_size` is encoded 0 = byte, 1 = word, 2 = longword, 3 = reserved. A word at an odd address, a longword at a nonzero address, or the reserved size raises `misalign_err`. In that case `byte_en`, `bus_wdata` and `load_data` are all zero.
- R5: Store data is replicated on every lane it could occupy: a byte four times, a word twice, a longword once. This is the same in both modes.
- R6: Little-endian loads: a byte at address a is taken from bits 8a+7:8a. A word at address 0 is taken from bits 15:0 and at address 2 from bits 31:16. Byte and word results are sign-extended to 32 bits.
- R7: Big-endian loads: a byte at address a is taken from lane 3-a. A word at address 0 is taken from bits 31:16 and at address 2 from bits 15:0. Results are sign-extended to 32 bits.
- R8: A longword load returns the bus word unchanged in either mode.
- R9: With `imm_zero_ext` low (arithmetic class), `imm_ext` is the 8-bit literal sign-extended to 32 bits.
- R10: With `imm_zero_ext` high (logic class), `imm_ext` is the literal zero-extended to 32 bits.
- R11: Every output is registered. `rsp_valid` and the results appear one clock after a request. A cycle without a request gives `rsp_valid` = 0 with all other outputs zero, and the same holds throughout reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; mode captured while low |
| cfg_big_endian | input | 1 | Endian selection pin, 1 = big-endian |
| req_valid | input | 1 | Request present this cycle |
| req_size | input | 2 | Access size code |
| req_addr | input | 2 | Low address bits of the access |
| store_data | input | 32 | Register data to be written |
| bus_rdata | input | 32 | Word returned by memory |
| imm_lit | input | 8 | Literal to extend |
| imm_zero_ext | input | 1 | 1 = logic class (zero-extend), 0 = arithmetic class |
| rsp_valid | output | 1 | Results valid, one cycle after request |
| misalign_err | output | 1 | Misaligned or reserved-size request |
| byte_en | output | 4 | Byte-lane strobes |
| bus_wdata | output | 32 | Lane-replicated store data |
| load_data | output | 32 | Extracted and sign-extended load result |
| imm_ext | output | 32 | Extended literal |

## Verification
The bench builds the aligner with its default four-lane bus and 8-bit literal. This makes every address and size combination of the 32-bit bus reachable, including the reserved size code and both misaligned shapes. The bench resets the block once in each endian mode and sweeps all byte and word positions in both. Bus words with their sign bits set in chosen lanes expose any lane swapped between the two mappings. Flipping the configuration pin after each reset shows whether the captured mode stays fixed.

// File: rtl/aligner_pkg.sv
package aligner_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_RSVD = 2'd3
    } size_e;

    // number of bytes named by a size code
    function automatic int size_bytes(input size_e sz);
        return 1 << int'(sz);
    endfunction

endpackage

// File: rtl/aligner_strobe.sv
module aligner_strobe
    import aligner_pkg::*;
#(
    parameter int BUS_BYTES = 4,
    parameter int AW        = $clog2(BUS_BYTES)
) (
    input  logic                 big_mode,
    input  size_e                size,
    input  logic [AW-1:0]        addr,
    output logic [BUS_BYTES-1:0] lane_en,
    output logic                 misaligned
);

    localparam int MAX_LOG = $clog2(BUS_BYTES);

    int nbytes;
    int base;

    always_comb begin
        nbytes     = size_bytes(size);
        base       = int'(addr);
        misaligned = (int'(size) > MAX_LOG) || ((base & (nbytes - 1)) != 0);
    end

    for (genvar l = 0; l < BUS_BYTES; l++) begin : g_lane
        int pos;
        always_comb begin
            // byte offset within the access window that lane l carries
            pos        = big_mode ? (BUS_BYTES - 1 - l) : l;
            lane_en[l] = !misaligned && (pos >= base) && (pos < base + nbytes);
        end
    end

endmodule

// File: rtl/aligner_replicate.sv
module aligner_replicate
    import aligner_pkg::*;
#(
    parameter int BUS_BYTES = 4,
    parameter int BUS_W     = 8 * BUS_BYTES
) (
    input  size_e             size,
    input  logic [BUS_W-1:0]  store_data,
    output logic [BUS_W-1:0]  bus_wdata
);

    // each lane repeats the datum byte whose index is the lane modulo the size
    for (genvar l = 0; l < BUS_BYTES; l++) begin : g_lane
        always_comb begin
            unique case (size)
                SZ_BYTE: bus_wdata[l*8 +: 8] = store_data[7:0];
                SZ_WORD: bus_wdata[l*8 +: 8] = store_data[(l % 2)*8 +: 8];
                SZ_LONG: bus_wdata[l*8 +: 8] = store_data[(l % 4)*8 +: 8];
                default: bus_wdata[l*8 +: 8] = store_data[(l % 8)*8 +: 8];
            endcase
        end
    end

endmodule

// File: rtl/aligner_extract.sv
module aligner_extract
    import aligner_pkg::*;
#(
    parameter int BUS_BYTES = 4,
    parameter int BUS_W     = 8 * BUS_BYTES,
    parameter int AW        = $clog2(BUS_BYTES)
) (
    input  logic              big_mode,
    input  size_e             size,
    input  logic [AW-1:0]     addr,
    input  logic [BUS_W-1:0]  bus_rdata,
    output logic [BUS_W-1:0]  load_data
);

    int                nbytes;
    int                nbits;
    int                start;
    logic [BUS_W-1:0]  shifted;
    logic [BUS_W-1:0]  keep_mask;
    logic [BUS_W-1:0]  sign_mask;
    logic              sign;

    always_comb begin
        nbytes = size_bytes(size);
        nbits  = 8 * nbytes;
        // lowest lane of the addressed window
        start  = big_mode ? (BUS_BYTES - int'(addr) - nbytes) : int'(addr);
        if (start < 0) begin
            start = 0;
        end
        shifted = bus_rdata >> (8 * start);
        for (int i = 0; i < BUS_W; i++) begin
            keep_mask[i] = (i < nbits);
            sign_mask[i] = (i == nbits - 1);
        end
        sign      = |(shifted & sign_mask);
        load_data = (shifted & keep_mask) | (sign ? ~keep_mask : '0);
    end

endmodule

// File: rtl/aligner_imm.sv
module aligner_imm #(
    parameter int IMM_W = 8,
    parameter int OUT_W = 32
) (
    input  logic [IMM_W-1:0] lit,
    input  logic             zero_ext,
    output logic [OUT_W-1:0] ext
);

    localparam int PAD_W = OUT_W - IMM_W;

    logic pad_bit;

    always_comb begin
        pad_bit = zero_ext ? 1'b0 : lit[IMM_W-1];
        ext     = {{PAD_W{pad_bit}}, lit};
    end

endmodule

// File: rtl/endian_aligner.sv
module endian_aligner
    import aligner_pkg::*;
#(
    parameter int BUS_BYTES = 4,
    parameter int IMM_W     = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_big_endian,
    input  logic                          req_valid,
    input  logic [1:0]                    req_size,
    input  logic [$clog2(BUS_BYTES)-1:0]  req_addr,
    input  logic [8*BUS_BYTES-1:0]        store_data,
    input  logic [8*BUS_BYTES-1:0]        bus_rdata,
    input  logic [IMM_W-1:0]              imm_lit,
    input  logic                          imm_zero_ext,
    output logic                          rsp_valid,
    output logic                          misalign_err,
    output logic [BUS_BYTES-1:0]          byte_en,
    output logic [8*BUS_BYTES-1:0]        bus_wdata,
    output logic [8*BUS_BYTES-1:0]        load_data,
    output logic [8*BUS_BYTES-1:0]        imm_ext
);

    localparam int BUS_W = 8 * BUS_BYTES;
    localparam int AW    = $clog2(BUS_BYTES);

    typedef struct packed {
        logic                 mode;
        logic                 valid;
        logic                 err;
        logic [BUS_BYTES-1:0] be;
        logic [BUS_W-1:0]     wdata;
        logic [BUS_W-1:0]     rdata;
        logic [BUS_W-1:0]     imm;
    } state_t;

    state_t state_d, state_q;

    size_e                size_w;
    logic                 mis_w;
    logic [BUS_BYTES-1:0] be_w;
    logic [BUS_W-1:0]     wdata_w;
    logic [BUS_W-1:0]     rdata_w;
    logic [BUS_W-1:0]     imm_w;

    assign size_w = size_e'(req_size);

    aligner_strobe #(.BUS_BYTES(BUS_BYTES), .AW(AW)) i_strobe (
        .big_mode   (state_q.mode),
        .size       (size_w),
        .addr       (req_addr),
        .lane_en    (be_w),
        .misaligned (mis_w)
    );

    aligner_replicate #(.BUS_BYTES(BUS_BYTES), .BUS_W(BUS_W)) i_replicate (
        .size       (size_w),
        .store_data (store_data),
        .bus_wdata  (wdata_w)
    );

    aligner_extract #(.BUS_BYTES(BUS_BYTES), .BUS_W(BUS_W), .AW(AW)) i_extract (
        .big_mode   (state_q.mode),
        .size       (size_w),
        .addr       (req_addr),
        .bus_rdata  (bus_rdata),
        .load_data  (rdata_w)
    );

    aligner_imm #(.IMM_W(IMM_W), .OUT_W(BUS_W)) i_imm (
        .lit      (imm_lit),
        .zero_ext (imm_zero_ext),
        .ext      (imm_w)
    );

    always_comb begin
        state_d      = '0;
        state_d.mode = state_q.mode;
        if (req_valid) begin
            state_d.valid = 1'b1;
            state_d.err   = mis_w;
            state_d.imm   = imm_w;
            if (!mis_w) begin
                state_d.be    = be_w;
                state_d.wdata = wdata_w;
                state_d.rdata = rdata_w;
            end
        end
        if (!rst_n) begin
            state_d      = '0;
            state_d.mode = cfg_big_endian;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign rsp_valid    = state_q.valid;
    assign misalign_err = state_q.err;
    assign byte_en      = state_q.be;
    assign bus_wdata    = state_q.wdata;
    assign load_data    = state_q.rdata;
    assign imm_ext      = state_q.imm;

endmodule

// File: rtl/aligner_checker.sv
module aligner_checker #(
    parameter int BUS_BYTES = 4,
    parameter int IMM_W     = 8
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          req_valid,
    input logic [1:0]                    req_size,
    input logic [$clog2(BUS_BYTES)-1:0]  req_addr,
    input logic                          imm_zero_ext,
    input logic                          rsp_valid,
    input logic                          misalign_err,
    input logic [BUS_BYTES-1:0]          byte_en,
    input logic [8*BUS_BYTES-1:0]        load_data,
    input logic [8*BUS_BYTES-1:0]        imm_ext
);

    localparam int BUS_W = 8 * BUS_BYTES;

    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R11

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && byte_en == '0 && !misalign_err)); // R11

    AST_ERR_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        misalign_err |-> (byte_en == '0 && load_data == '0)); // R4

    AST_ODD_WORD_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == 2'd1 && req_addr[0]) |=> misalign_err); // R4

    AST_STROBE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !misalign_err) |-> ($countones(byte_en) == (1 << $past(req_size)))); // R2

    AST_BYTE_LOAD_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !misalign_err && $past(req_size) == 2'd0)
        |-> (load_data[BUS_W-1:8] == {(BUS_W-8){load_data[7]}})); // R6

    AST_IMM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(imm_zero_ext)) |-> (imm_ext[BUS_W-1:IMM_W] == '0)); // R10

    AST_IMM_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !$past(imm_zero_ext))
        |-> (imm_ext[BUS_W-1:IMM_W] == {(BUS_W-IMM_W){imm_ext[IMM_W-1]}})); // R9

endmodule

bind endian_aligner aligner_checker #(.BUS_BYTES(BUS_BYTES), .IMM_W(IMM_W)) i_aligner_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_size     (req_size),
    .req_addr     (req_addr),
    .imm_zero_ext (imm_zero_ext),
    .rsp_valid    (rsp_valid),
    .misalign_err (misalign_err),
    .byte_en      (byte_en),
    .load_data    (load_data),
    .imm_ext      (imm_ext)
);

// File: tb/test_endian_aligner.sv
`timescale 1ns/1ps
module test_endian_aligner;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_big_endian = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_size = '0;
    logic [1:0]  req_addr = '0;
    logic [31:0] store_data = '0;
    logic [31:0] bus_rdata = '0;
    logic [7:0]  imm_lit = '0;
    logic        imm_zero_ext = 1'b0;
    logic        rsp_valid;
    logic        misalign_err;
    logic [3:0]  byte_en;
    logic [31:0] bus_wdata;
    logic [31:0] load_data;
    logic [31:0] imm_ext;

    always #2.5 clk = ~clk;

    endian_aligner i_endian_aligner (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_big_endian (cfg_big_endian),
        .req_valid      (req_valid),
        .req_size       (req_size),
        .req_addr       (req_addr),
        .store_data     (store_data),
        .bus_rdata      (bus_rdata),
        .imm_lit        (imm_lit),
        .imm_zero_ext   (imm_zero_ext),
        .rsp_valid      (rsp_valid),
        .misalign_err   (misalign_err),
        .byte_en        (byte_en),
        .bus_wdata      (bus_wdata),
        .load_data      (load_data),
        .imm_ext        (imm_ext)
    );

    typedef struct {
        logic        v;
        logic        e;
        logic [3:0]  be;
        logic [31:0] wd;
        logic [31:0] rd;
        logic [31:0] im;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   mon_on = 0;
    bit   done   = 0;
    logic ref_big = 1'b0;

    function automatic exp_t model(input logic big, input logic v, input logic [1:0] sz,
                                   input logic [1:0] ad, input logic [31:0] sd,
                                   input logic [31:0] rd, input logic [7:0] lit,
                                   input logic z, input string tag);
        exp_t r;
        logic [7:0]  b;
        logic [15:0] w;
        int          lane;
        int          half;
        r = '{v:1'b0, e:1'b0, be:4'h0, wd:32'h0, rd:32'h0, im:32'h0, tag:tag};
        if (!v) return r;
        r.v  = 1'b1;
        r.im = z ? {24'h0, lit} : {{24{lit[7]}}, lit};
        r.e  = (sz == 2'd3) || (sz == 2'd1 && ad[0]) || (sz == 2'd2 && ad != 2'd0);
        if (r.e) return r;
        case (sz)
            2'd0: begin
                lane = big ? 3 - int'(ad) : int'(ad);
                r.be = 4'b0001 << lane;
                r.wd = {4{sd[7:0]}};
                b    = rd[lane*8 +: 8];
                r.rd = {{24{b[7]}}, b};
            end
            2'd1: begin
                half = big ? (ad == 2'd0 ? 1 : 0) : (ad == 2'd2 ? 1 : 0);
                r.be = half == 1 ? 4'b1100 : 4'b0011;
                r.wd = {2{sd[15:0]}};
                w    = rd[half*16 +: 16];
                r.rd = {{16{w[15]}}, w};
            end
            default: begin
                r.be = 4'b1111;
                r.wd = sd;
                r.rd = rd;
            end
        endcase
        return r;
    endfunction

    task automatic issue(input logic v, input logic [1:0] sz, input logic [1:0] ad,
                         input logic [31:0] sd, input logic [31:0] rd,
                         input logic [7:0] lit, input logic z, input string tag);
        @(negedge clk);
        req_valid    = v;
        req_size     = sz;
        req_addr     = ad;
        store_data   = sd;
        bus_rdata    = rd;
        imm_lit      = lit;
        imm_zero_ext = z;
        q.push_back(model(ref_big, v, sz, ad, sd, rd, lit, z, tag));
    endtask

    // monitor: one result per request, sampled after the capturing edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (mon_on && q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (rsp_valid !== e.v || misalign_err !== e.e || byte_en !== e.be ||
                    bus_wdata !== e.wd || load_data !== e.rd || imm_ext !== e.im) begin
                    errors++;
                    $display("FAIL %s: act v=%b e=%b be=%b wd=%h rd=%h im=%h exp v=%b e=%b be=%b wd=%h rd=%h im=%h",
                             e.tag, rsp_valid, misalign_err, byte_en, bus_wdata, load_data, imm_ext,
                             e.v, e.e, e.be, e.wd, e.rd, e.im);
                end
            end
        end
    end

    task automatic drain();
        while (q.size() > 0) @(posedge clk);
        #2;
    endtask

    task automatic do_reset(input logic big);
        drain();
        mon_on = 0;
        @(negedge clk);
        rst_n     = 1'b0;
        req_valid = 1'b1;
        cfg_big_endian = big;
        repeat (2) @(negedge clk);
        checks++; // R11 reset state
        if (rsp_valid !== 1'b0 || misalign_err !== 1'b0 || byte_en !== 4'h0 ||
            bus_wdata !== 32'h0 || load_data !== 32'h0 || imm_ext !== 32'h0) begin
            errors++;
            $display("FAIL R11 reset: act v=%b e=%b be=%b exp all zero", rsp_valid, misalign_err, byte_en);
        end
        ref_big   = big;
        req_valid = 1'b0;
        rst_n     = 1'b1;
        mon_on    = 1;
    endtask

    task automatic sweep(input string t_be, input string t_ld);
        for (int a = 0; a < 4; a++) begin
            issue(1, 2'd0, 2'(a), 32'h0000_00A5 + 32'(a), 32'h80_7F_C3_11 ^ (32'h0101_0101 << a),
                  8'h80, 0, {t_be, " R5 ", t_ld, " R9 byte"});
        end
        issue(1, 2'd1, 2'd0, 32'h1234_8765, 32'h8001_7FFE, 8'h7F, 1, {t_be, " R5 ", t_ld, " R10 word0"});
        issue(1, 2'd1, 2'd2, 32'hDEAD_0102, 32'h7001_9ABC, 8'hC0, 1, {t_be, " R5 ", t_ld, " R10 word2"});
        issue(1, 2'd2, 2'd0, 32'hCAFE_F00D, 32'h8123_4567, 8'h01, 0, {t_be, " R5 R8 long"});
        issue(1, 2'd1, 2'd1, 32'h1111_2222, 32'hFFFF_FFFF, 8'hFF, 0, "R4 odd word");
        issue(1, 2'd1, 2'd3, 32'h1111_2222, 32'hFFFF_FFFF, 8'hFF, 1, "R4 odd word 3");
        issue(1, 2'd2, 2'd2, 32'h3333_4444, 32'hFFFF_FFFF, 8'h80, 1, "R4 long addr2");
        issue(1, 2'd2, 2'd1, 32'h3333_4444, 32'hFFFF_FFFF, 8'h00, 0, "R4 long addr1");
        issue(1, 2'd3, 2'd0, 32'h5555_6666, 32'hFFFF_FFFF, 8'h5A, 0, "R4 reserved size");
        issue(0, 2'd2, 2'd0, 32'h7777_8888, 32'h1234_5678, 8'h80, 0, "R11 idle");
        issue(1, 2'd0, 2'd2, 32'h0000_0080, 32'h00_80_00_00, 8'h80, 1, {t_ld, " R10 R11 back-to-back"});
    endtask

    initial begin
        do_reset(1'b0);
        sweep("R2", "R6");
        // R1: pin flipped after reset must not change the mapping
        @(negedge clk);
        cfg_big_endian = 1'b1;
        issue(1, 2'd0, 2'd0, 32'h0000_0042, 32'h11_22_33_F4, 8'h00, 0, "R1 R2 little held");
        issue(1, 2'd1, 2'd0, 32'h0000_ABCD, 32'h1122_8344, 8'h00, 0, "R1 R6 little held");

        do_reset(1'b1);
        sweep("R3", "R7");
        @(negedge clk);
        cfg_big_endian = 1'b0;
        issue(1, 2'd0, 2'd0, 32'h0000_0042, 32'hF4_22_33_11, 8'h00, 0, "R1 R3 big held");
        issue(1, 2'd1, 2'd0, 32'h0000_ABCD, 32'h8344_1122, 8'h00, 0, "R1 R7 big held");
        drain();

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #250000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: act hung exp finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule